// File: doc/BRIEF.md
# Per-Port LED Indicator Driver

This block drives the four indicator LEDs of one network port. Every LED has its own small configuration: a source code that chooses which of the port's event signals it shows, a polarity bit for active-low or active-high wiring, and a blink bit that makes an active event flash instead of glowing steadily. Event inputs such as link up, speed grades and traffic activity come from logic outside the block. The block decodes them and registers the four pin levels.

After reset every LED sits at its off level. The first default-load strobe after reset copies a configuration word read from non-volatile storage into the configuration register, so the board gets its preferred LED scheme without software. Software may then rewrite the register through a single-cycle write port. A write always wins over a default load in the same cycle. All flashing LEDs share one free-running divider, so they flash in step.

Top module: `led_indicator_drv`

## Requirements
- R1: While reset is asserted and after its release with no load or write, every LED field holds source code 15, polarity 0 and blink 0, so all four pins read 0.
- R2: LED i is configured by bits [6i+3:6i] (source code), bit 6i+4 (invert) and bit 6i+5 (blink) of the configuration word. A source code k below NUM_EVENTS makes the LED follow event input bit k.
- R3: A source code of NUM_EVENTS or above (8 to 15 by default) drives the LED to its off level, 0 before polarity.
- R4: With the invert bit set, the pin level is the complement of the level decided by source selection and blink gating; the invert step comes last.
- R5: With the blink bit set, an active selected event gives the current blink phase on the LED, and an inactive selected event gives the off level whatever the phase.
- R6: The blink phase is 0 after reset and flips once every BLINK_HALF clock cycles, and all blinking LEDs use the same phase. With k clock edges since reset release, the pin after edge k shows phase floor((k-1)/BLINK_HALF) mod 2.
- R7: The pins are registered: an event change is visible one clock edge later, and a configuration write is visible on the pins at the second edge after it is presented.
- R8: The first default-load strobe after reset copies the default word into the configuration register; any later strobe before the next reset is ignored.
- R9: A configuration write in the same cycle as a default-load strobe is taken instead of the default, and any write disarms the default load until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_i | input | NUM_EVENTS | Event signals that LEDs may show, active high |
| cfg_we | input | 1 | Configuration write strobe, one cycle |
| cfg_wdata | input | NUM_LEDS*6 | Configuration word for a write |
| dflt_ld | input | 1 | Default-load strobe |
| dflt_word | input | NUM_LEDS*6 | Power-on configuration word from non-volatile storage |
| led_o | output | NUM_LEDS | LED pin levels |

## Verification
An event change presented between edges shows on the pins after exactly one rising edge, and a write or default load presented between edges is registered at the first edge and reaches the pins at the second, so the bench drives on the falling edge and samples on a later falling edge after the matching number of rising edges. The latency checks also look once just before the due edge to confirm that the old value still holds. For flashing, the bench counts rising edges since reset release itself and derives the expected phase from that count and the half period, then compares on every falling edge across several full periods. Ignored default loads are checked by watching the pins two edges after the strobe.

// File: rtl/led_ind_pkg.sv
`timescale 1ns/1ps
package led_ind_pkg;
  localparam int LED_MODE_W  = 4;
  localparam int LED_SRC_MAX = 1 << LED_MODE_W;

  // One LED field: mode in the low bits, invert above it, blink on top.
  typedef struct packed {
    logic                  blink;
    logic                  invert;
    logic [LED_MODE_W-1:0] mode;
  } led_cfg_t;

  localparam int LED_CFG_W = $bits(led_cfg_t);

  localparam led_cfg_t LED_CFG_RST = '{blink: 1'b0, invert: 1'b0, mode: '1};

  // Source selection: codes past the populated events read as off.
  function automatic logic pick_event(input logic [LED_SRC_MAX-1:0] evs,
                                      input logic [LED_MODE_W-1:0]  mode,
                                      input int unsigned            n_ev);
    return (int'(mode) < int'(n_ev)) ? evs[mode] : 1'b0;
  endfunction

  // Blink gating: an active event follows the phase, an idle one is off.
  function automatic logic gate_blink(input logic ev, input logic blink_en,
                                      input logic phase);
    return ev & (~blink_en | phase);
  endfunction

  // Polarity is the last step before the pin register.
  function automatic logic apply_pol(input logic lvl, input logic inv);
    return lvl ^ inv;
  endfunction
endpackage

// File: rtl/led_blink_gen.sv
`timescale 1ns/1ps
module led_blink_gen #(
  parameter int HALF_PERIOD = 20_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o,
  output logic phase_o
);
  localparam int CNT_W = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             phase_q;

  assign tick_o  = (cnt_q == CNT_LAST);
  assign phase_o = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (tick_o) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/led_cfg_bank.sv
`timescale 1ns/1ps
module led_cfg_bank
  import led_ind_pkg::*;
#(
  parameter int NUM_LEDS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [NUM_LEDS*LED_CFG_W-1:0] wr_data,
  input  logic                          dflt_ld,
  input  logic [NUM_LEDS*LED_CFG_W-1:0] dflt_data,
  output led_cfg_t [NUM_LEDS-1:0]       cfg_o,
  output logic                          armed_o,
  output logic                          take_o
);
  led_cfg_t [NUM_LEDS-1:0] cfg_q;
  logic                    armed_q;

  // A write in the same cycle beats the default load.
  assign take_o  = dflt_ld & armed_q & ~wr_en;
  assign cfg_o   = cfg_q;
  assign armed_o = armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LEDS; i++) cfg_q[i] <= LED_CFG_RST;
      armed_q <= 1'b1;
    end else if (wr_en) begin
      cfg_q   <= wr_data;
      armed_q <= 1'b0;
    end else if (take_o) begin
      cfg_q   <= dflt_data;
      armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/led_lane.sv
`timescale 1ns/1ps
module led_lane
  import led_ind_pkg::*;
#(
  parameter int NUM_EVENTS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  led_cfg_t              cfg_i,
  input  logic [NUM_EVENTS-1:0] ev_i,
  input  logic                  phase_i,
  output logic                  sel_o,
  output logic                  on_o,
  output logic                  led_o
);
  logic [LED_SRC_MAX-1:0] ev_pad;
  logic                   led_q;

  always_comb begin
    ev_pad                 = '0;
    ev_pad[NUM_EVENTS-1:0] = ev_i;
  end

  assign sel_o = pick_event(ev_pad, cfg_i.mode, NUM_EVENTS);
  assign on_o  = gate_blink(sel_o, cfg_i.blink, phase_i);
  assign led_o = led_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) led_q <= 1'b0;
    else        led_q <= apply_pol(on_o, cfg_i.invert);
  end
endmodule

// File: rtl/led_indicator_drv.sv
`timescale 1ns/1ps
module led_indicator_drv
  import led_ind_pkg::*;
#(
  parameter int NUM_LEDS   = 4,
  parameter int NUM_EVENTS = 8,
  parameter int BLINK_HALF = 20_000_000,
  localparam int WORD_W    = NUM_LEDS * LED_CFG_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_EVENTS-1:0] ev_i,
  input  logic                  cfg_we,
  input  logic [WORD_W-1:0]     cfg_wdata,
  input  logic                  dflt_ld,
  input  logic [WORD_W-1:0]     dflt_word,
  output logic [NUM_LEDS-1:0]   led_o
);
  // Internal events brought out by name for the checker.
  logic                    blink_tick;
  logic                    blink_ph;
  logic                    dflt_armed;
  logic                    dflt_take;
  logic [NUM_LEDS-1:0]     lane_sel;
  logic [NUM_LEDS-1:0]     lane_on;
  led_cfg_t [NUM_LEDS-1:0] cfg;

  led_blink_gen #(.HALF_PERIOD(BLINK_HALF)) u_blink (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_o  (blink_tick),
    .phase_o (blink_ph)
  );

  led_cfg_bank #(.NUM_LEDS(NUM_LEDS)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_we),
    .wr_data   (cfg_wdata),
    .dflt_ld   (dflt_ld),
    .dflt_data (dflt_word),
    .cfg_o     (cfg),
    .armed_o   (dflt_armed),
    .take_o    (dflt_take)
  );

  for (genvar g = 0; g < NUM_LEDS; g++) begin : g_lane
    led_lane #(.NUM_EVENTS(NUM_EVENTS)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_i   (cfg[g]),
      .ev_i    (ev_i),
      .phase_i (blink_ph),
      .sel_o   (lane_sel[g]),
      .on_o    (lane_on[g]),
      .led_o   (led_o[g])
    );
  end
endmodule

// File: rtl/led_indicator_drv_chk.sv
`timescale 1ns/1ps
module led_indicator_drv_chk #(
  parameter int NUM_LEDS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_we,
  input logic                dflt_ld,
  input logic                blink_tick,
  input logic                blink_ph,
  input logic                dflt_armed,
  input logic                dflt_take,
  input logic [NUM_LEDS-1:0] lane_sel,
  input logic [NUM_LEDS-1:0] lane_on
);
  assert_load_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dflt_take |=> !dflt_armed);

  assert_no_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !dflt_armed |=> !dflt_take);

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && dflt_ld) |-> !dflt_take);

  assert_write_disarms_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !dflt_armed);

  assert_phase_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    blink_tick |=> (blink_ph != $past(blink_ph)));

  assert_phase_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !blink_tick |=> $stable(blink_ph));

  for (genvar g = 0; g < NUM_LEDS; g++) begin : g_idle
    assert_idle_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_sel[g] |-> !lane_on[g]);
  end
endmodule

bind led_indicator_drv led_indicator_drv_chk #(.NUM_LEDS(NUM_LEDS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .dflt_ld    (dflt_ld),
  .blink_tick (blink_tick),
  .blink_ph   (blink_ph),
  .dflt_armed (dflt_armed),
  .dflt_take  (dflt_take),
  .lane_sel   (lane_sel),
  .lane_on    (lane_on)
);

// File: tb/tb_led_indicator_drv.sv
`timescale 1ns/1ps
module tb_led_indicator_drv;
  localparam int NL = 4;
  localparam int NE = 8;
  localparam int HB = 8;
  localparam int WW = NL * 6;
  localparam int NV = 7;

  // Field of one LED: {blink, invert, mode[3:0]}.
  function automatic logic [5:0] lc(input bit b, input bit i, input int m);
    return {b, i, 4'(m)};
  endfunction

  // Entry: {config word, events, expected pins}.
  localparam logic [WW+NE+NL-1:0] VEC [NV] = '{
    {lc(0,0,3), lc(0,0,2), lc(0,0,1), lc(0,0,0), 8'h05, 4'b0101},
    {lc(0,0,3), lc(0,0,2), lc(0,0,1), lc(0,0,0), 8'h0A, 4'b1010},
    {lc(0,0,4), lc(0,0,5), lc(0,0,6), lc(0,0,7), 8'hA0, 4'b0101},
    {lc(0,1,3), lc(0,1,2), lc(0,1,1), lc(0,1,0), 8'h03, 4'b1100},
    {lc(0,1,9), lc(0,1,0), lc(0,0,15), lc(0,0,8), 8'hFF, 4'b1000},
    {lc(0,0,2), lc(0,0,2), lc(0,1,2), lc(0,0,2), 8'h04, 4'b1101},
    {lc(1,1,12), lc(0,0,2), lc(1,1,1), lc(1,0,0), 8'h00, 4'b1010}
  };
  localparam string TAG [NV] = '{"R2", "R2", "R2", "R4", "R3", "R4", "R5"};

  localparam logic [WW-1:0] STEADY = {lc(0,0,3), lc(0,0,2), lc(0,0,1), lc(0,0,0)};
  localparam logic [WW-1:0] INVALL = {lc(0,1,3), lc(0,1,2), lc(0,1,1), lc(0,1,0)};
  localparam logic [WW-1:0] BLINKW = {lc(0,0,0), lc(1,0,1), lc(1,1,1), lc(1,0,0)};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NE-1:0] ev_i = '0;
  logic          cfg_we = 1'b0;
  logic [WW-1:0] cfg_wdata = '0;
  logic          dflt_ld = 1'b0;
  logic [WW-1:0] dflt_word = '0;
  logic [NL-1:0] led_o;

  int checks = 0;
  int errors = 0;
  int ncyc   = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ncyc <= 0;
    else        ncyc <= ncyc + 1;
  end

  led_indicator_drv #(.NUM_LEDS(NL), .NUM_EVENTS(NE), .BLINK_HALF(HB)) dut (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .dflt_ld(dflt_ld), .dflt_word(dflt_word),
    .led_o(led_o)
  );

  task automatic check(input string req, input logic [NL-1:0] act,
                       input logic [NL-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s led_o=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cfg_we = 1'b0; dflt_ld = 1'b0; ev_i = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic write_cfg(input logic [WW-1:0] w);
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(5ns * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ev_i = 8'hFF;
    repeat (2) @(negedge clk);
    check("R1 reset state off", led_o, 4'b0000);

    // R8: first default load is taken.
    ev_i = 8'h06;
    dflt_ld = 1'b1; dflt_word = STEADY;
    @(negedge clk);
    dflt_ld = 1'b0;
    @(negedge clk);
    check("R8 default loaded", led_o, 4'b0110);
    // R8: a second strobe is ignored.
    dflt_ld = 1'b1; dflt_word = INVALL;
    @(negedge clk);
    dflt_ld = 1'b0;
    @(negedge clk);
    check("R8 second load ignored", led_o, 4'b0110);

    // R7: event latency of one edge.
    ev_i = 8'h09;
    #1;
    check("R7 no combinational path", led_o, 4'b0110);
    @(negedge clk);
    check("R7 event after one edge", led_o, 4'b1001);

    // R7: write latency of two edges.
    cfg_we = 1'b1; cfg_wdata = INVALL;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R7 write not yet on pins", led_o, 4'b1001);
    @(negedge clk);
    check("R7 write on pins", led_o, 4'b0110);

    // Table walk: R2 R3 R4 R5.
    for (int v = 0; v < NV; v++) begin
      ev_i = VEC[v][NL +: NE];
      write_cfg(VEC[v][NL+NE +: WW]);
      check(TAG[v], led_o, VEC[v][NL-1:0]);
    end

    // R9: write beats default load in the same cycle, and disarms it.
    do_reset();
    ev_i = 8'h03;
    cfg_we = 1'b1; cfg_wdata = STEADY;
    dflt_ld = 1'b1; dflt_word = INVALL;
    @(negedge clk);
    cfg_we = 1'b0; dflt_ld = 1'b0;
    @(negedge clk);
    check("R9 write wins", led_o, 4'b0011);
    dflt_ld = 1'b1;
    @(negedge clk);
    dflt_ld = 1'b0;
    @(negedge clk);
    check("R9 load disarmed by write", led_o, 4'b0011);

    // R6 R5 R4: blink phase from edge count, shared by all blinking LEDs.
    do_reset();
    ev_i = 8'h03;
    write_cfg(BLINKW);
    for (int c = 0; c < 4 * HB; c++) begin
      logic ph;
      ph = 1'(((ncyc - 1) / HB) % 2);
      check("R6 blink phase", led_o, {1'b1, ph, ~ph, ph});
      @(negedge clk);
    end
    ev_i = 8'h02;
    repeat (2) @(negedge clk);
    check("R5 idle blink off", led_o, 4'b0000 | {1'b0, 1'(((ncyc - 1) / HB) % 2),
          ~1'(((ncyc - 1) / HB) % 2), 1'b0});

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule